// File: doc/BRIEF.md
# Parallel Port Reverse-Channel Read Handshake

This block is the peripheral side of a PC parallel-port style link, limited to the direction where the peripheral returns bytes to the host. The host starts each read by pulling an active-low request strobe low. The block then takes the byte at the head of a local byte FIFO and drives it onto the eight data lines. After a fixed setup time it raises its busy handshake. The host raises its strobe again to finish. The block then releases busy after a short, fixed number of clock cycles, and only at that point does it remove the byte from the FIFO.

There are two transfer modes, chosen by a mode input that is captured when the data lines start to be driven:

- **Byte mode.** The whole byte appears on the lines at once. The lines are released to high impedance as soon as the host's rising strobe is seen.
- **Nibble mode.** Only the upper half of the byte is presented before busy rises. The lower half is added to lines 3:0 once the host's rising strobe has been seen.

The strobe is asynchronous to the block clock and passes through a two-stage synchronizer before edge detection.

The controller has five named states:

- **IDLE.** Nothing is driven and busy is low. IDLE→WAIT on a detected strobe fall with the FIFO empty. IDLE→SETUP on a detected strobe fall with the FIFO not empty.
- **WAIT.** Nothing is driven and busy is low. WAIT→SETUP once the FIFO is not empty.
- **SETUP.** Data is driven and busy is low. SETUP→HOLD after the setup count expires.
- **HOLD.** Data is driven and busy is high. HOLD→REL when the synchronized strobe is high.
- **REL.** Busy is still high and the FIFO is popped. REL→IDLE after the release count expires.

Top module: `pp_rd_link`

## Requirements
- R1: While reset is asserted and after its release, with no strobe activity, `periph_busy`, `pd_oe` and `fifo_pop` are all 0.
- R2: A falling `host_req_n` that is first sampled at clock edge k, with the FIFO not empty, sets `pd_oe` to 1 after edge k+2 and not earlier. `periph_busy` rises after edge k+2+SETUP_CYC, where SETUP_CYC = 3*ADC_DIV/2 (12 by default).
- R3: In byte mode (`nib_mode`=0), `pd_out` equals the full captured byte from the time the lines are driven until the host's rising strobe is acted on.
- R4: In nibble mode (`nib_mode`=1), `pd_out` is {byte[7:4], 4'b0000} before the rising strobe is acted on. From then on, until busy falls, it is {byte[7:4], byte[3:0]}.
- R5: A rising `host_req_n` first sampled at edge m leaves `periph_busy` high through edge m+2 and drops it after edge m+2+REL_HOLD (m+3 by default, 3.5 clock periods after the pin rises).
- R6: In byte mode `pd_oe` drops after edge m+2 while `periph_busy` is still high. In both modes `pd_oe` is 0 whenever `periph_busy` has just fallen.
- R7: If the FIFO is empty when a read starts, neither the data lines nor busy are driven until `fifo_empty` is 0. The edge that first samples it at 0 starts the data drive, and the R2 setup delay counts from that edge.
- R8: `fifo_pop` is a single-cycle pulse, one per transfer, asserted in the last cycle that `periph_busy` is high and never earlier in the transfer.
- R9: `nib_mode` is captured when the data drive starts. Changing it later in the transfer has no effect on `pd_out` or `pd_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req_n | input | 1 | Active-low host read strobe, asynchronous |
| nib_mode | input | 1 | 1 = nibble transfers, 0 = byte transfers |
| fifo_empty | input | 1 | FIFO has no byte available |
| fifo_data | input | DW (8) | Byte at the FIFO head |
| fifo_pop | output | 1 | Removes the FIFO head byte |
| pd_out | output | DW (8) | Value for the data lines |
| pd_oe | output | 1 | Data line output enable |
| periph_busy | output | 1 | Peripheral handshake to the host |

## Verification
Each handshake is run in both modes with a set of bytes: all zeros, all ones, alternating bit patterns, and values whose two halves differ. These separate a correct nibble split from a swapped, duplicated or unmasked lower half, and a full byte drive from a partial one. Every transfer is sampled cycle by cycle around both strobe edges, which tells a synchronizer or release count that is off by one from the correct one. Transfers that start with an empty FIFO separate a block that waits from one that drives stale data. Flipping the mode input in the middle of every transfer shows whether the mode is captured or read live.

// File: rtl/pp_rd_pkg.sv
package pp_rd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_SETUP,
        ST_HOLD,
        ST_REL
    } rd_state_t;

endpackage

// File: rtl/pp_rd_sync.sv
module pp_rd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic lvl,
    output logic fell,
    output logic rose
);
    logic [STAGES:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh[0] <= 1'b1;
        else        sh[0] <= pin_n;
    end

    for (genvar i = 1; i <= STAGES; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh[i] <= 1'b1;
            else        sh[i] <= sh[i-1];
        end
    end

    assign lvl  = sh[STAGES-1];
    assign fell = sh[STAGES] & ~sh[STAGES-1];
    assign rose = ~sh[STAGES] & sh[STAGES-1];
endmodule

// File: rtl/pp_rd_fsm.sv
module pp_rd_fsm
    import pp_rd_pkg::*;
#(
    parameter int DW        = 8,
    parameter int SETUP_CYC = 12,
    parameter int REL_HOLD  = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_fell,
    input  logic          req_lvl,
    input  logic          nib_mode,
    input  logic          fifo_empty,
    input  logic [DW-1:0] fifo_data,
    output logic          busy,
    output logic          drive,
    output logic          phase_lo,
    output logic          pop,
    output logic          mode_q,
    output logic [DW-1:0] data_q
);
    localparam int MAXC = (SETUP_CYC > REL_HOLD) ? SETUP_CYC : REL_HOLD;
    localparam int CW   = $clog2(MAXC) + 1;
    localparam logic [CW-1:0] SET_LAST = CW'(SETUP_CYC - 1);
    localparam logic [CW-1:0] REL_LAST = CW'(REL_HOLD - 1);

    rd_state_t     state, nxt;
    logic [CW-1:0] cnt;
    logic          start;

    assign start = ((state == ST_IDLE) && req_fell && !fifo_empty) ||
                   ((state == ST_WAIT) && !fifo_empty);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (req_fell) nxt = fifo_empty ? ST_WAIT : ST_SETUP;
            ST_WAIT:  if (!fifo_empty) nxt = ST_SETUP;
            ST_SETUP: if (cnt == SET_LAST) nxt = ST_HOLD;
            ST_HOLD:  if (req_lvl) nxt = ST_REL;
            ST_REL:   if (cnt == REL_LAST) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            mode_q <= 1'b0;
            data_q <= '0;
        end else begin
            state <= nxt;
            cnt   <= (nxt != state) ? '0 : cnt + 1'b1;
            if (start) begin
                mode_q <= nib_mode;
                data_q <= fifo_data;
            end
        end
    end

    always_comb begin
        busy     = 1'b0;
        drive    = 1'b0;
        phase_lo = 1'b0;
        pop      = 1'b0;
        unique case (state)
            ST_IDLE, ST_WAIT: ;
            ST_SETUP: drive = 1'b1;
            ST_HOLD: begin
                drive = 1'b1;
                busy  = 1'b1;
            end
            ST_REL: begin
                busy     = 1'b1;
                drive    = mode_q;
                phase_lo = 1'b1;
                pop      = (cnt == REL_LAST);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pp_rd_lanes.sv
module pp_rd_lanes #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] data_q,
    input  logic          mode_q,
    input  logic          phase_lo,
    input  logic          drive,
    output logic [DW-1:0] pd_out,
    output logic          pd_oe
);
    localparam int NW = DW / 2;

    always_comb begin
        if (mode_q && !phase_lo) pd_out = {data_q[DW-1:NW], {NW{1'b0}}};
        else                     pd_out = data_q;
        pd_oe = drive;
    end
endmodule

// File: rtl/pp_rd_link.sv
module pp_rd_link #(
    parameter int DW       = 8,
    parameter int ADC_DIV  = 8,
    parameter int REL_HOLD = 1,
    parameter int SYNC_FF  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_req_n,
    input  logic          nib_mode,
    input  logic          fifo_empty,
    input  logic [DW-1:0] fifo_data,
    output logic          fifo_pop,
    output logic [DW-1:0] pd_out,
    output logic          pd_oe,
    output logic          periph_busy
);
    localparam int SETUP_CYC = (3 * ADC_DIV) / 2;

    logic          req_lvl, req_fell, req_rose;
    logic          drive, phase_lo, mode_q;
    logic [DW-1:0] data_q;

    pp_rd_sync #(.STAGES(SYNC_FF)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_n (host_req_n),
        .lvl   (req_lvl),
        .fell  (req_fell),
        .rose  (req_rose)
    );

    pp_rd_fsm #(.DW(DW), .SETUP_CYC(SETUP_CYC), .REL_HOLD(REL_HOLD)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_fell   (req_fell),
        .req_lvl    (req_lvl),
        .nib_mode   (nib_mode),
        .fifo_empty (fifo_empty),
        .fifo_data  (fifo_data),
        .busy       (periph_busy),
        .drive      (drive),
        .phase_lo   (phase_lo),
        .pop        (fifo_pop),
        .mode_q     (mode_q),
        .data_q     (data_q)
    );

    pp_rd_lanes #(.DW(DW)) u_lanes (
        .data_q   (data_q),
        .mode_q   (mode_q),
        .phase_lo (phase_lo),
        .drive    (drive),
        .pd_out   (pd_out),
        .pd_oe    (pd_oe)
    );

    logic rose_seen_unused;
    assign rose_seen_unused = req_rose;
endmodule

// File: rtl/pp_rd_link_chk.sv
module pp_rd_link_chk (
    input logic clk,
    input logic rst_n,
    input logic host_req_n,
    input logic fifo_pop,
    input logic pd_oe,
    input logic periph_busy
);
    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_quiet_r1: assert (!periph_busy && !pd_oe && !fifo_pop)
                else $error("R1 outputs active in reset");
        end
    end

    p_drive_before_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(periph_busy) |-> pd_oe);

    p_busy_drop_after_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |=> !periph_busy);

    p_lines_off_at_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(periph_busy) |-> !pd_oe);

    p_pop_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |=> !fifo_pop);

    p_pop_while_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> (periph_busy && host_req_n));
endmodule

bind pp_rd_link pp_rd_link_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_req_n  (host_req_n),
    .fifo_pop    (fifo_pop),
    .pd_oe       (pd_oe),
    .periph_busy (periph_busy)
);

// File: tb/pp_rd_link_test.sv
module pp_rd_link_test;
    localparam int SETUP_CYC = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_req_n = 1'b1;
    logic       nib_mode = 1'b0;
    logic       fifo_empty = 1'b1;
    logic [7:0] fifo_data = 8'h00;
    logic       fifo_pop;
    logic [7:0] pd_out;
    logic       pd_oe;
    logic       periph_busy;

    int n_run = 0;
    int n_fail = 0;
    int pops = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pp_rd_link uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_req_n  (host_req_n),
        .nib_mode    (nib_mode),
        .fifo_empty  (fifo_empty),
        .fifo_data   (fifo_data),
        .fifo_pop    (fifo_pop),
        .pd_out      (pd_out),
        .pd_oe       (pd_oe),
        .periph_busy (periph_busy)
    );

    always @(posedge clk) if (rst_n && fifo_pop) pops <= pops + 1;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] d, input bit nib, input bit empty_first);
        logic [7:0] first;
        logic [7:0] last_v;
        int         p0;
        first  = nib ? {d[7:4], 4'h0} : d;
        last_v = d;
        p0     = pops;
        fifo_data  = d;
        nib_mode   = nib;
        fifo_empty = empty_first;
        host_req_n = 1'b0;
        if (empty_first) begin
            tick(6);
            chk(!pd_oe && !periph_busy, "R7 idle while empty", {pd_oe, periph_busy}, 0);
            fifo_empty = 1'b0;
            tick(1);
        end else begin
            tick(2);
            chk(!pd_oe, "R2 no drive before edge k+2", pd_oe, 0);
            tick(1);
        end
        chk(pd_oe && !periph_busy, "R2 drive starts", {pd_oe, periph_busy}, 2'b10);
        chk(pd_out == first, nib ? "R4 upper nibble first" : "R3 full byte", pd_out, first);
        nib_mode = ~nib;
        tick(SETUP_CYC - 1);
        chk(!periph_busy, "R2 busy still low", periph_busy, 0);
        tick(1);
        chk(periph_busy && pd_oe, "R2 busy rises", {periph_busy, pd_oe}, 2'b11);
        chk(pd_out == first, "R9 R3 R4 data held", pd_out, first);
        tick(3);
        chk(!fifo_pop && periph_busy, "R8 no early pop", {fifo_pop, periph_busy}, 2'b01);
        host_req_n = 1'b1;
        tick(2);
        chk(periph_busy && !fifo_pop && pd_out == first, "R5 busy through m+2",
            {periph_busy, fifo_pop, pd_out}, {2'b10, first});
        tick(1);
        chk(periph_busy && fifo_pop, "R8 pop in last busy cycle",
            {periph_busy, fifo_pop}, 2'b11);
        chk(pd_oe == nib, "R6 R9 enable after strobe rise", pd_oe, nib);
        if (nib) chk(pd_out == last_v, "R4 lower nibble added", pd_out, last_v);
        tick(1);
        chk(!periph_busy && !pd_oe && !fifo_pop, "R5 R6 busy released",
            {periph_busy, pd_oe, fifo_pop}, 0);
        chk(pops == p0 + 1, "R8 one pop per transfer", pops, p0 + 1);
        nib_mode = nib;
        tick(2);
    endtask

    initial begin
        tick(1);
        chk(!periph_busy && !pd_oe && !fifo_pop, "R1 reset state",
            {periph_busy, pd_oe, fifo_pop}, 0);
        tick(3);
        rst_n = 1'b1;
        fifo_empty = 1'b0;
        fifo_data = 8'hC3;
        tick(5);
        chk(!periph_busy && !pd_oe && !fifo_pop, "R1 quiet without strobe",
            {periph_busy, pd_oe, fifo_pop}, 0);
        for (int m = 0; m < 2; m++) begin
            xfer(8'h00, bit'(m), 1'b0);
            xfer(8'hFF, bit'(m), 1'b0);
            xfer(8'hA5, bit'(m), 1'b0);
            xfer(8'h5A, bit'(m), 1'b0);
            for (int i = 0; i < 12; i++) xfer(8'(i * 77 + 19), bit'(m), 1'b0);
            xfer(8'h3C, bit'(m), 1'b1);
            xfer(8'h96, bit'(m), 1'b1);
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule